// File: doc/BRIEF.md
# Mobile DRAM Power-State Sequencer

This block sits between the command scheduler of a DRAM controller and a low-power DDR memory device. It takes charge of the device's two low-power states: clock stop and deep power-down. The scheduler asks to enter either state, and later asks to wake. The sequencer tracks the most recent access command and the timing window that command opens. It drives the memory clock-enable (CKE), a clock-gate enable for the memory clock and the command bus while a state change is under way. While a transition or low-power state is in progress it withholds its grant from the scheduler.

Clock stop keeps CKE high and gates the clock. The device keeps its contents, and after the clock restarts a parameterised number of NOP cycles must pass before the scheduler may issue again. Deep power-down is entered with the burst-terminate encoding issued in the same cycle that CKE falls. CKE stays low for a minimum number of cycles. Leaving deep power-down loses all stored data. After CKE rises and an exit delay has passed, the block raises `init_required` and holds the scheduler off until an external initialisation sequencer reports that it has finished. All delays are counted in controller clock cycles.

Command encoding on the 3-bit command buses, written as {RAS#, CAS#, WE#}: 000 mode-register set, 001 auto refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst terminate, 111 NOP. The first six are access commands. The state output `pstate` encodes 0 ACTIVE, 1 CLK_STOPPED, 2 DPD and 3 REINIT.

Top module: `dram_lp_sequencer`

## Requirements
- R1: After reset the block has `pstate`=0, `mem_cke`=1, `mem_clk_en`=1, `mem_cmd`=111 (NOP), `sched_grant`=1 and `init_required`=0.
- R2: In ACTIVE, `mem_cmd` equals `sched_cmd` in any cycle where `sched_valid` is 1, and equals NOP (111) when `sched_valid` is 0. `sched_grant` is 1.
- R3: Each access command opens a settle window of W cycles, where W is T_RCD for activate, T_RD for read, T_WR for write, T_RP for precharge, T_RFC for auto refresh and T_MRD for mode-register set. If the command is presented in cycle c, `clock_stop_ok` is 0 in cycles c+1 to c+W and may be 1 from cycle c+W+1. Burst terminate and NOP open no window.
- R4: `clock_stop_ok` is 0 whenever `rd_burst_active` is 1, and also whenever an access command is being presented in the current cycle or `pstate` is not ACTIVE. A clock-stop request made while `clock_stop_ok` is 0 is ignored.
- R5: A `req_clk_stop` made in ACTIVE while `clock_stop_ok` is 1 (and `req_dpd` is 0) causes the next cycle to have `mem_clk_en`=0, `mem_cke`=1, `pstate`=1 and `sched_grant`=0.
- R6: A `req_wake` made in clock stop sets `mem_clk_en`=1 in the next cycle. It is followed by exactly N_NOP cycles with `mem_cmd`=NOP and `sched_grant`=0, and after those `pstate`=0 and `sched_grant`=1.
- R7: An accepted deep power-down request causes the next cycle to drive `mem_cmd`=110 (burst terminate) with `mem_cke`=0 and `pstate`=2. That is the only burst-terminate cycle; the following cycles drive NOP with CKE still low.
- R8: A `req_dpd` made in ACTIVE while any bit of `banks_open` is 1, while a settle window (R3) is still running, or while an access command is being presented raises `dpd_reject` in the same cycle and leaves the state at ACTIVE.
- R9: CKE stays low for at least T_CKE cycles, counting the burst-terminate cycle. A wake request is taken only once that count is reached, and `mem_cke` rises in the cycle after the wake is taken.
- R10: From the cycle in which CKE rises after deep power-down, `pstate`=3, `init_required`=1 and `sched_grant`=0 for T_XP cycles in which `init_done` is ignored. After that the block waits for `init_done`; in the cycle after it is seen, `pstate`=0 and `init_required`=0.
- R11: When `req_dpd` and `req_clk_stop` are both raised in ACTIVE, the deep power-down request is served and the clock-stop request is dropped.
- R12: Outside ACTIVE, `sched_valid` and `sched_cmd` have no effect: `mem_cmd` is NOP except in the single burst-terminate cycle. `req_dpd` and `req_clk_stop` are ignored while the clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_valid | input | 1 | Scheduler presents a command this cycle |
| sched_cmd | input | 3 | Scheduler command {RAS#,CAS#,WE#} |
| sched_grant | output | 1 | Scheduler may issue (ACTIVE only) |
| banks_open | input | NBANK | One bit per bank, 1 = row open |
| rd_burst_active | input | 1 | Read data-out burst in progress |
| req_clk_stop | input | 1 | Request to stop the memory clock |
| req_dpd | input | 1 | Request to enter deep power-down |
| req_wake | input | 1 | Request to leave the current low-power state |
| init_done | input | 1 | External initialisation sequence complete |
| mem_cke | output | 1 | Memory clock enable |
| mem_clk_en | output | 1 | Gate enable for the memory clock |
| mem_cmd | output | 3 | Command to the memory {RAS#,CAS#,WE#} |
| clock_stop_ok | output | 1 | Clock stop is currently allowed |
| dpd_reject | output | 1 | Deep power-down request refused this cycle |
| init_required | output | 1 | Full re-initialisation pending |
| pstate | output | 2 | 0 ACTIVE, 1 CLK_STOPPED, 2 DPD, 3 REINIT |

## Verification
`mem_cmd`, `clock_stop_ok` and `dpd_reject` respond in the cycle in which their input is presented. Every request changes `pstate`, `mem_cke` and `mem_clk_en` exactly one cycle later, because a single state register lies on that path. The multi-cycle results fall at fixed cycles counted from the request: a settle window closes at cycle W+1 after the command, CKE rises at cycle T_CKE+1 after the burst-terminate cycle, the grant returns N_NOP cycles after the clock restarts, and ACTIVE returns T_XP+1 cycles after CKE rises if `init_done` is already high. The bench drives inputs just after a rising edge and samples in the middle of the same cycle. It walks forward one edge at a time and compares each cycle index against an expected value computed from these cycle counts.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    PS_ACTIVE      = 2'd0,
    PS_CLK_STOPPED = 2'd1,
    PS_DPD         = 2'd2,
    PS_REINIT      = 2'd3
  } pstate_e;

  typedef enum logic [2:0] {
    S_RUN,
    S_STOP,
    S_RESTART,
    S_DPD_ENT,
    S_DPD,
    S_DPD_XP,
    S_REINIT
  } seq_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_access(input logic [2:0] c);
    return (c != CMD_BST) && (c != CMD_NOP);
  endfunction

  // Settle window opened by a command, in controller cycles.
  function automatic int unsigned settle_cycles(
    input logic [2:0] c,
    input int unsigned t_rcd, input int unsigned t_rd, input int unsigned t_wr,
    input int unsigned t_rp, input int unsigned t_rfc, input int unsigned t_mrd);
    case (c)
      CMD_ACT: return t_rcd;
      CMD_RD:  return t_rd;
      CMD_WR:  return t_wr;
      CMD_PRE: return t_rp;
      CMD_REF: return t_rfc;
      CMD_MRS: return t_mrd;
      default: return 0;
    endcase
  endfunction

  function automatic pstate_e visible_state(input seq_e s);
    case (s)
      S_STOP, S_RESTART: return PS_CLK_STOPPED;
      S_DPD_ENT, S_DPD:  return PS_DPD;
      S_DPD_XP, S_REINIT: return PS_REINIT;
      default:           return PS_ACTIVE;
    endcase
  endfunction

endpackage

// File: rtl/dls_cmd_timer.sv
module dls_cmd_timer import dls_pkg::*; #(
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RD  = 4,
  parameter int unsigned T_WR  = 5,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RFC = 12,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned TW    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  logic [2:0] cmd,
  output logic       idle
);

  logic [TW-1:0] remain;
  logic [TW-1:0] load_val;

  assign load_val = TW'(settle_cycles(cmd, T_RCD, T_RD, T_WR, T_RP, T_RFC, T_MRD));

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (issue)          remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign idle = (remain == '0);

endmodule

// File: rtl/dls_phase_cnt.sv
module dls_phase_cnt #(
  parameter int unsigned PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  output logic          done
);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/dls_ctrl.sv
module dls_ctrl import dls_pkg::*; #(
  parameter int unsigned T_CKE = 2,
  parameter int unsigned T_XP  = 2,
  parameter int unsigned N_NOP = 1,
  parameter int unsigned PW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_dpd,
  input  logic          req_clk_stop,
  input  logic          req_wake,
  input  logic          init_done,
  input  logic          banks_closed,
  input  logic          timer_idle,
  input  logic          access_now,
  input  logic          stop_ok,
  input  logic          phase_done,
  output seq_e          state,
  output logic          phase_load,
  output logic [PW-1:0] phase_val,
  output logic          ev_dpd_enter,
  output logic          ev_stop_enter,
  output logic          ev_dpd_exit,
  output logic          dpd_reject
);

  localparam int unsigned CKE_LOW = (T_CKE < 2) ? 2 : T_CKE;
  localparam int unsigned XP_CYC  = (T_XP  < 1) ? 1 : T_XP;
  localparam int unsigned NOP_CYC = (N_NOP < 1) ? 1 : N_NOP;

  seq_e nxt;
  logic dpd_ok;
  logic in_run;

  assign in_run        = (state == S_RUN);
  assign dpd_ok        = banks_closed && timer_idle && !access_now;
  assign ev_dpd_enter  = in_run && req_dpd && dpd_ok;
  assign dpd_reject    = in_run && req_dpd && !dpd_ok;
  assign ev_stop_enter = in_run && !req_dpd && req_clk_stop && stop_ok;
  assign ev_dpd_exit   = (state == S_DPD) && req_wake && phase_done;

  always_comb begin
    nxt        = state;
    phase_load = 1'b0;
    phase_val  = '0;
    case (state)
      S_RUN: begin
        if (ev_dpd_enter) begin
          nxt        = S_DPD_ENT;
          phase_load = 1'b1;
          phase_val  = PW'(CKE_LOW - 1);
        end else if (ev_stop_enter) begin
          nxt = S_STOP;
        end
      end
      S_STOP: begin
        if (req_wake) begin
          nxt        = S_RESTART;
          phase_load = 1'b1;
          phase_val  = PW'(NOP_CYC - 1);
        end
      end
      S_RESTART: if (phase_done) nxt = S_RUN;
      S_DPD_ENT: nxt = S_DPD;
      S_DPD: begin
        if (ev_dpd_exit) begin
          nxt        = S_DPD_XP;
          phase_load = 1'b1;
          phase_val  = PW'(XP_CYC - 1);
        end
      end
      S_DPD_XP: if (phase_done) nxt = S_REINIT;
      S_REINIT: if (init_done)  nxt = S_RUN;
      default:  nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_RUN;
    else        state <= nxt;
  end

endmodule

// File: rtl/dram_lp_sequencer.sv
module dram_lp_sequencer import dls_pkg::*; #(
  parameter int unsigned NBANK = 8,
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RD  = 4,
  parameter int unsigned T_WR  = 5,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RFC = 12,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned T_CKE = 2,
  parameter int unsigned T_XP  = 2,
  parameter int unsigned N_NOP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sched_valid,
  input  logic [2:0]       sched_cmd,
  output logic             sched_grant,
  input  logic [NBANK-1:0] banks_open,
  input  logic             rd_burst_active,
  input  logic             req_clk_stop,
  input  logic             req_dpd,
  input  logic             req_wake,
  input  logic             init_done,
  output logic             mem_cke,
  output logic             mem_clk_en,
  output logic [2:0]       mem_cmd,
  output logic             clock_stop_ok,
  output logic             dpd_reject,
  output logic             init_required,
  output logic [1:0]       pstate
);

  localparam int unsigned T_MAX = umax(umax(umax(T_RCD, T_RD), umax(T_WR, T_RP)),
                                       umax(umax(T_RFC, T_MRD), 1));
  localparam int unsigned TW    = $clog2(T_MAX + 1);
  localparam int unsigned P_MAX = umax(umax(T_CKE, T_XP), umax(N_NOP, 2));
  localparam int unsigned PW    = $clog2(P_MAX + 1);

  seq_e          state;
  logic          access_now;
  logic          issue;
  logic          timer_idle;
  logic          phase_load;
  logic [PW-1:0] phase_val;
  logic          phase_done;
  logic          ev_dpd_enter;
  logic          ev_stop_enter;
  logic          ev_dpd_exit;
  logic          in_run;

  assign in_run     = (state == S_RUN);
  assign access_now = sched_valid && is_access(sched_cmd);
  assign issue      = in_run && access_now;

  dls_cmd_timer #(
    .T_RCD(T_RCD), .T_RD(T_RD), .T_WR(T_WR), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .TW(TW)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (issue),
    .cmd   (sched_cmd),
    .idle  (timer_idle)
  );

  assign clock_stop_ok = in_run && timer_idle && !rd_burst_active && !access_now;

  dls_phase_cnt #(.PW(PW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_load),
    .load_val (phase_val),
    .done     (phase_done)
  );

  dls_ctrl #(
    .T_CKE(T_CKE), .T_XP(T_XP), .N_NOP(N_NOP), .PW(PW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_dpd       (req_dpd),
    .req_clk_stop  (req_clk_stop),
    .req_wake      (req_wake),
    .init_done     (init_done),
    .banks_closed  (banks_open == '0),
    .timer_idle    (timer_idle),
    .access_now    (access_now),
    .stop_ok       (clock_stop_ok),
    .phase_done    (phase_done),
    .state         (state),
    .phase_load    (phase_load),
    .phase_val     (phase_val),
    .ev_dpd_enter  (ev_dpd_enter),
    .ev_stop_enter (ev_stop_enter),
    .ev_dpd_exit   (ev_dpd_exit),
    .dpd_reject    (dpd_reject)
  );

  always_comb begin
    if (state == S_DPD_ENT)         mem_cmd = CMD_BST;
    else if (in_run && sched_valid) mem_cmd = sched_cmd;
    else                            mem_cmd = CMD_NOP;
  end

  assign mem_cke       = !((state == S_DPD_ENT) || (state == S_DPD));
  assign mem_clk_en    = (state != S_STOP);
  assign sched_grant   = in_run;
  assign init_required = (state == S_DPD_XP) || (state == S_REINIT);
  assign pstate        = visible_state(state);

endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int unsigned NBANK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] banks_open,
  input logic             init_done,
  input logic             mem_cke,
  input logic             mem_clk_en,
  input logic [2:0]       mem_cmd,
  input logic             sched_grant,
  input logic             clock_stop_ok,
  input logic             dpd_reject,
  input logic             init_required,
  input logic [1:0]       pstate,
  input logic             ev_dpd_enter,
  input logic             ev_stop_enter
);

  localparam logic [2:0] BST = 3'b110;
  localparam logic [2:0] NOP = 3'b111;

  assert_stop_needs_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_clk_en) |-> $past(clock_stop_ok));

  assert_stop_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop_enter |=> (!mem_clk_en && mem_cke && pstate == 2'd1));

  assert_cke_high_when_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_clk_en |-> mem_cke);

  assert_restart_nop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_clk_en) |-> (mem_cmd == NOP && !sched_grant));

  assert_dpd_banks_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dpd_enter |-> (banks_open == '0));

  assert_dpd_entry_bst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dpd_enter |=> (mem_cmd == BST && !mem_cke));

  assert_single_bst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == BST && !mem_cke) |=> (mem_cmd == NOP));

  assert_reject_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dpd_reject |=> (pstate == 2'd0 && mem_cke));

  assert_cke_min_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> !$past(mem_cke, 2));

  assert_init_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_required) |-> $past(init_done));

  assert_blocked_outside_active_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate != 2'd0) |-> (!sched_grant && (mem_cmd == NOP || (mem_cmd == BST && !mem_cke))));

endmodule

bind dram_lp_sequencer dls_checker #(.NBANK(NBANK)) u_dls_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .banks_open    (banks_open),
  .init_done     (init_done),
  .mem_cke       (mem_cke),
  .mem_clk_en    (mem_clk_en),
  .mem_cmd       (mem_cmd),
  .sched_grant   (sched_grant),
  .clock_stop_ok (clock_stop_ok),
  .dpd_reject    (dpd_reject),
  .init_required (init_required),
  .pstate        (pstate),
  .ev_dpd_enter  (ev_dpd_enter),
  .ev_stop_enter (ev_stop_enter)
);

// File: tb/tb_dram_lp_sequencer.sv
module tb_dram_lp_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NBANK = 4;
  localparam int T_RCD = 2;
  localparam int T_RD  = 3;
  localparam int T_WR  = 4;
  localparam int T_RP  = 2;
  localparam int T_RFC = 5;
  localparam int T_MRD = 1;
  localparam int T_CKE = 3;
  localparam int T_XP  = 2;
  localparam int N_NOP = 2;

  localparam logic [2:0] C_ACT = 3'b011;
  localparam logic [2:0] C_RD  = 3'b101;
  localparam logic [2:0] C_WR  = 3'b100;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam logic [2:0] C_BST = 3'b110;
  localparam logic [2:0] C_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sched_valid = 1'b0;
  logic [2:0] sched_cmd = C_NOP;
  logic sched_grant;
  logic [NBANK-1:0] banks_open = '0;
  logic rd_burst_active = 1'b0;
  logic req_clk_stop = 1'b0;
  logic req_dpd = 1'b0;
  logic req_wake = 1'b0;
  logic init_done = 1'b0;
  logic mem_cke, mem_clk_en, clock_stop_ok, dpd_reject, init_required;
  logic [2:0] mem_cmd;
  logic [1:0] pstate;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_lp_sequencer #(
    .NBANK(NBANK), .T_RCD(T_RCD), .T_RD(T_RD), .T_WR(T_WR), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .T_CKE(T_CKE), .T_XP(T_XP), .N_NOP(N_NOP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sched_valid(sched_valid), .sched_cmd(sched_cmd),
    .sched_grant(sched_grant), .banks_open(banks_open), .rd_burst_active(rd_burst_active),
    .req_clk_stop(req_clk_stop), .req_dpd(req_dpd), .req_wake(req_wake),
    .init_done(init_done), .mem_cke(mem_cke), .mem_clk_en(mem_clk_en),
    .mem_cmd(mem_cmd), .clock_stop_ok(clock_stop_ok), .dpd_reject(dpd_reject),
    .init_required(init_required), .pstate(pstate)
  );

  function automatic int exp_wait(input logic [2:0] c);
    if (c == C_ACT) return T_RCD;
    if (c == C_RD)  return T_RD;
    if (c == C_WR)  return T_WR;
    if (c == C_PRE) return T_RP;
    if (c == 3'b001) return T_RFC;
    if (c == 3'b000) return T_MRD;
    return -1;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    sched_valid = 0; req_clk_stop = 0; req_dpd = 0; req_wake = 0;
    repeat (n) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 pstate", pstate, 0);
    chk("R1 cke", mem_cke, 1);
    chk("R1 clk_en", mem_clk_en, 1);
    chk("R1 cmd", mem_cmd, C_NOP);
    chk("R1 grant", sched_grant, 1);
    chk("R1 init_required", init_required, 0);

    // R2 and R3: sweep every command encoding
    for (int ci = 0; ci < 8; ci++) begin
      logic [2:0] c;
      int w;
      c = 3'(ci);
      w = exp_wait(c);
      idle(8);
      chk("R2 idle cmd", mem_cmd, C_NOP);
      chk("R2 grant", sched_grant, 1);
      sched_valid = 1; sched_cmd = c;
      #1;
      chk("R2 pass", mem_cmd, c);
      chk("R4 ok low while issuing", clock_stop_ok, (w < 0) ? 1 : 0);
      tick();
      sched_valid = 0;
      #1;
      if (w < 0) begin
        chk("R3 no window", clock_stop_ok, 1);
      end else begin
        for (int k = 1; k <= w + 2; k++) begin
          chk("R3 window", clock_stop_ok, (k >= w + 1) ? 1 : 0);
          tick();
        end
      end
    end

    // R4 read burst blocks clock stop
    idle(8);
    rd_burst_active = 1; req_clk_stop = 1;
    #1;
    chk("R4 burst", clock_stop_ok, 0);
    tick();
    req_clk_stop = 0;
    #1;
    chk("R4 stop ignored", pstate, 0);
    rd_burst_active = 0;
    #1;
    chk("R4 burst over", clock_stop_ok, 1);

    // R5 request during window ignored
    sched_valid = 1; sched_cmd = C_WR;
    tick();
    sched_valid = 0; req_clk_stop = 1;
    #1;
    chk("R5 ok in window", clock_stop_ok, 0);
    tick();
    req_clk_stop = 0;
    #1;
    chk("R5 ignored pstate", pstate, 0);
    chk("R5 ignored clk_en", mem_clk_en, 1);

    // R5 accepted
    idle(8);
    req_clk_stop = 1;
    #1;
    chk("R5 ok", clock_stop_ok, 1);
    tick();
    req_clk_stop = 0;
    #1;
    chk("R5 clk_en", mem_clk_en, 0);
    chk("R5 cke", mem_cke, 1);
    chk("R5 pstate", pstate, 1);
    chk("R5 grant", sched_grant, 0);

    // R12 inputs ignored while stopped
    sched_valid = 1; sched_cmd = C_RD; req_dpd = 1;
    #1;
    chk("R12 cmd forced", mem_cmd, C_NOP);
    tick();
    req_dpd = 0; sched_cmd = C_ACT;
    #1;
    chk("R12 dpd ignored", pstate, 1);
    chk("R12 still gated", mem_clk_en, 0);

    // R6 restart with NOPs, scheduler holding an activate
    req_wake = 1;
    tick();
    req_wake = 0;
    #1;
    for (int i = 0; i <= N_NOP; i++) begin
      chk("R6 clk_en", mem_clk_en, 1);
      chk("R6 grant", sched_grant, (i == N_NOP) ? 1 : 0);
      chk("R6 cmd", mem_cmd, (i == N_NOP) ? C_ACT : C_NOP);
      chk("R6 pstate", pstate, (i == N_NOP) ? 0 : 1);
      tick();
    end
    sched_valid = 0;

    // R8 rejection: open bank
    idle(8);
    banks_open = 4'b0100; req_dpd = 1;
    #1;
    chk("R8 reject bank", dpd_reject, 1);
    tick();
    req_dpd = 0; banks_open = '0;
    #1;
    chk("R8 stays active", pstate, 0);
    chk("R8 cke", mem_cke, 1);

    // R8 rejection: precharge window running
    sched_valid = 1; sched_cmd = C_PRE;
    tick();
    sched_valid = 0; req_dpd = 1;
    #1;
    chk("R8 reject window", dpd_reject, 1);
    tick();
    req_dpd = 0;
    #1;
    chk("R8 window stays active", pstate, 0);

    // R11 both requests: deep power-down wins; R7 entry
    idle(8);
    req_dpd = 1; req_clk_stop = 1;
    #1;
    chk("R8 accept no reject", dpd_reject, 0);
    tick();
    req_dpd = 0; req_clk_stop = 0;
    #1;
    chk("R11 pstate dpd", pstate, 2);
    chk("R11 clock running", mem_clk_en, 1);
    chk("R7 bst", mem_cmd, C_BST);
    chk("R7 cke low", mem_cke, 0);

    // R9 min low time with wake held from the first low cycle
    req_wake = 1;
    for (int k = 1; k <= T_CKE; k++) begin
      chk("R9 cke low", mem_cke, 0);
      chk("R7 single bst", mem_cmd, (k == 1) ? C_BST : C_NOP);
      tick();
    end
    chk("R9 cke high", mem_cke, 1);

    // R10 exit delay and wait for init_done
    req_wake = 0; init_done = 0; sched_valid = 1; sched_cmd = C_ACT;
    for (int j = 0; j <= T_XP + 2; j++) begin
      #1;
      chk("R10 pstate", pstate, 3);
      chk("R10 init_required", init_required, 1);
      chk("R10 grant", sched_grant, 0);
      chk("R12 cmd blocked", mem_cmd, C_NOP);
      tick();
    end
    init_done = 1;
    #1;
    chk("R10 still reinit", pstate, 3);
    tick();
    init_done = 0; sched_valid = 0;
    #1;
    chk("R10 back active", pstate, 0);
    chk("R10 init cleared", init_required, 0);
    chk("R10 grant back", sched_grant, 1);

    // R10 init_done ignored during exit delay
    idle(4);
    req_dpd = 1;
    tick();
    req_dpd = 0; req_wake = 1; init_done = 1;
    repeat (T_CKE) tick();
    req_wake = 0;
    #1;
    chk("R9 second exit", mem_cke, 1);
    for (int j = 0; j <= T_XP; j++) begin
      chk("R10 early done ignored", pstate, 3);
      tick();
    end
    chk("R10 active after delay", pstate, 0);
    init_done = 0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule